// File: doc/BRIEF.md
# SPI Register Access Controller

This block turns the byte stream delivered by an SPI slave into register accesses on a small GPIO map. Each access is two bytes long. The first byte is a command byte: a direction flag and a 7-bit register address. The second byte is the data slot. In a write, the master's second byte goes into an LED register. In a read, the slave places the selected register's value in the transmit byte, ready before the second slot is shifted out.

The map has five entries:

| Address | Contents | Access |
|---|---|---|
| 0x00 | Constant identifier 0x07 | read only |
| 0x01 | Low switch byte | read only |
| 0x02 | High switch byte | read only |
| 0x03 | Low LED byte | read and write |
| 0x04 | High LED byte | read and write |

Any other address reads as zero and takes no writes. The SPI slave supplies a one-cycle strobe with each received byte. This block uses the strobe alone to track whether the next byte is a command or a data slot.

Top module: `spi_regctl`

## Requirements
- R1: After a synchronous reset (rst high at a clock edge), led_out is 0x0000, tx_byte is 0x00 and the next strobed byte is treated as a command byte.
- R2: Command byte format: bit 7 is the direction (1 = read, 0 = write) and bits 6:0 are the address. Strobes alternate strictly between command byte and data byte.
- R3: After a read command to address 0x00, tx_byte shows 0x07 from the cycle after the command strobe until the data strobe.
- R4: After a read command to 0x01 or 0x02, tx_byte shows switches bits 7:0 or 15:8 respectively, and follows the switch inputs live while the command is open.
- R5: After a read command to 0x03 or 0x04, tx_byte shows LED bits 7:0 or 15:8 respectively.
- R6: For a write command to 0x03 or 0x04, the data byte strobe loads LED bits 7:0 or 15:8. The new value is visible on led_out in the cycle after that strobe.
- R7: A write to 0x00, 0x01, 0x02 or an unmapped address leaves led_out unchanged. The master's data byte in a read also leaves led_out unchanged.
- R8: A read of an address above 0x04 returns 0x00 on tx_byte.
- R9: tx_byte is 0x00 while a command byte is awaited and during a write command.
- R10: Cycles without rx_valid change neither led_out nor the command/data alternation, whatever rx_byte carries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| rx_byte | input | 8 | Byte received from the SPI slave |
| rx_valid | input | 1 | One-cycle strobe marking rx_byte as new |
| sw_in | input | 16 | Switch inputs |
| led_out | output | 16 | LED register contents |
| tx_byte | output | 8 | Byte for the SPI slave to send in the next slot |

## Verification
Every later access depends on the phase bit. If it is wrong, a command byte is taken as data: either an address byte lands in an LED register, or read data appears one strobe late. Both show at the ports by the next strobe. A wrongly latched direction flag shows as tx_byte staying zero on a read, or as LEDs changing on a read. A faulty address decode shows as the wrong register byte on tx_byte in the cycle right after the command strobe.

// File: rtl/spi_regctl.sv
module spi_regctl #(
  parameter int          BW      = 8,
  parameter logic [BW-1:0] CHIP_ID = 8'h07
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [BW-1:0]   rx_byte,
  input  logic            rx_valid,
  input  logic [2*BW-1:0] sw_in,
  output logic [2*BW-1:0] led_out,
  output logic [BW-1:0]   tx_byte
);
  localparam int AW = BW - 1;
  localparam logic [AW-1:0] A_ID     = AW'(0);
  localparam logic [AW-1:0] A_SW_LO  = AW'(1);
  localparam logic [AW-1:0] A_SW_HI  = AW'(2);
  localparam logic [AW-1:0] A_LED_LO = AW'(3);
  localparam logic [AW-1:0] A_LED_HI = AW'(4);

  logic          phase;
  logic          cmd_rd;
  logic [AW-1:0] cmd_addr;
  logic [BW-1:0] led_lo, led_hi;
  logic [BW-1:0] rd_val;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase    <= 1'b0;
      cmd_rd   <= 1'b0;
      cmd_addr <= '0;
    end else if (rx_valid) begin
      phase <= ~phase;
      if (!phase) begin
        cmd_rd   <= rx_byte[BW-1];
        cmd_addr <= rx_byte[AW-1:0];
      end
    end
  end

  wire wr_slot = rx_valid && phase && !cmd_rd;

  always_ff @(posedge clk) begin
    if (rst) begin
      led_lo <= '0;
      led_hi <= '0;
    end else if (wr_slot) begin
      if (cmd_addr == A_LED_LO) led_lo <= rx_byte;
      if (cmd_addr == A_LED_HI) led_hi <= rx_byte;
    end
  end

  always_comb begin
    case (cmd_addr)
      A_ID:     rd_val = CHIP_ID;
      A_SW_LO:  rd_val = sw_in[BW-1:0];
      A_SW_HI:  rd_val = sw_in[2*BW-1:BW];
      A_LED_LO: rd_val = led_lo;
      A_LED_HI: rd_val = led_hi;
      default:  rd_val = '0;
    endcase
  end

  assign led_out = {led_hi, led_lo};
  assign tx_byte = (phase && cmd_rd) ? rd_val : '0;
endmodule

// File: rtl/spi_regctl_chk.sv
module spi_regctl_chk #(
  parameter int BW = 8
) (
  input logic            clk,
  input logic            rst,
  input logic [BW-1:0]   rx_byte,
  input logic            rx_valid,
  input logic [2*BW-1:0] sw_in,
  input logic [2*BW-1:0] led_out,
  input logic [BW-1:0]   tx_byte,
  input logic            phase,
  input logic            cmd_rd,
  input logic [BW-2:0]   cmd_addr
);
  AST_PHASE_TOGGLE: assert property (@(posedge clk) disable iff (rst)
    rx_valid |=> (phase != $past(phase))); // R2
  AST_PHASE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !rx_valid |=> $stable(phase)); // R10
  AST_LED_HOLD: assert property (@(posedge clk) disable iff (rst)
    !rx_valid |=> $stable(led_out)); // R10
  AST_NO_STRAY_WRITE: assert property (@(posedge clk) disable iff (rst)
    (rx_valid && !(phase && !cmd_rd)) |=> $stable(led_out)); // R7
  AST_ID_READ: assert property (@(posedge clk) disable iff (rst)
    (phase && cmd_rd && cmd_addr == 'd0) |-> tx_byte == 8'h07); // R3
  AST_SW_LO_READ: assert property (@(posedge clk) disable iff (rst)
    (phase && cmd_rd && cmd_addr == 'd1) |-> tx_byte == sw_in[BW-1:0]); // R4
  AST_LED_HI_READ: assert property (@(posedge clk) disable iff (rst)
    (phase && cmd_rd && cmd_addr == 'd4) |-> tx_byte == led_out[2*BW-1:BW]); // R5
  AST_LED_LO_WRITE: assert property (@(posedge clk) disable iff (rst)
    (rx_valid && phase && !cmd_rd && cmd_addr == 'd3) |=> led_out[BW-1:0] == $past(rx_byte)); // R6
  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (rst)
    (phase && cmd_rd && cmd_addr > 'd4) |-> tx_byte == '0); // R8
  AST_TX_QUIET: assert property (@(posedge clk) disable iff (rst)
    !(phase && cmd_rd) |-> tx_byte == '0); // R9
endmodule

bind spi_regctl spi_regctl_chk #(.BW(BW)) u_chk (
  .clk(clk), .rst(rst), .rx_byte(rx_byte), .rx_valid(rx_valid),
  .sw_in(sw_in), .led_out(led_out), .tx_byte(tx_byte),
  .phase(phase), .cmd_rd(cmd_rd), .cmd_addr(cmd_addr)
);

// File: tb/spi_regctl_test.sv
module spi_regctl_test;
  logic        clk = 1'b0;
  logic        rst;
  logic [7:0]  rx_byte;
  logic        rx_valid;
  logic [15:0] sw_in;
  logic [15:0] led_out;
  logic [7:0]  tx_byte;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  spi_regctl uut (
    .clk(clk), .rst(rst), .rx_byte(rx_byte), .rx_valid(rx_valid),
    .sw_in(sw_in), .led_out(led_out), .tx_byte(tx_byte)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] b);
    rx_byte  = b;
    rx_valid = 1'b1;
    @(negedge clk);
    rx_valid = 1'b0;
    rx_byte  = 8'hA5;
    @(negedge clk);
  endtask

  task automatic do_write(input logic [6:0] a, input logic [7:0] d);
    send({1'b0, a});
    chk("R9 write cmd tx", {8'h0, tx_byte}, 16'h0);
    send(d);
  endtask

  task automatic do_read(input string req, input logic [6:0] a, input logic [7:0] exp);
    logic [15:0] led_before;
    send({1'b1, a});
    chk(req, {8'h0, tx_byte}, {8'h0, exp});
    led_before = led_out;
    send(8'hFF);
    chk("R7 read data byte ignored", led_out, led_before);
    chk("R9 idle tx", {8'h0, tx_byte}, 16'h0);
  endtask

  task automatic t_reset;
    rst = 1'b1; rx_valid = 1'b0; rx_byte = 8'h00; sw_in = 16'h0000;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 leds after reset", led_out, 16'h0000);
    chk("R1 tx after reset", {8'h0, tx_byte}, 16'h0);
  endtask

  task automatic t_reads;
    sw_in = 16'hC35A;
    do_read("R3 chip id", 7'h00, 8'h07);
    do_read("R4 switch low", 7'h01, 8'h5A);
    do_read("R4 switch high", 7'h02, 8'hC3);
    send(8'h81);
    sw_in = 16'h0096;
    @(negedge clk);
    chk("R4 switch live", {8'h0, tx_byte}, 16'h0096);
    send(8'h00);
    do_read("R8 unmapped 05", 7'h05, 8'h00);
    do_read("R8 unmapped 7F", 7'h7F, 8'h00);
  endtask

  task automatic t_writes;
    do_write(7'h03, 8'h3C);
    chk("R6 led low write", led_out, 16'h003C);
    do_write(7'h04, 8'hE1);
    chk("R6 led high write", led_out, 16'hE13C);
    do_read("R5 led low read", 7'h03, 8'h3C);
    do_read("R5 led high read", 7'h04, 8'hE1);
    do_write(7'h00, 8'h11);
    chk("R7 write id ignored", led_out, 16'hE13C);
    do_write(7'h01, 8'h22);
    chk("R7 write sw low ignored", led_out, 16'hE13C);
    do_write(7'h02, 8'h33);
    chk("R7 write sw high ignored", led_out, 16'hE13C);
    do_write(7'h43, 8'h44);
    chk("R7 write unmapped ignored", led_out, 16'hE13C);
    do_read("R3 id after writes", 7'h00, 8'h07);
  endtask

  task automatic t_idle_noise;
    for (int i = 0; i < 6; i++) begin
      rx_byte = 8'h83 + 8'(i);
      @(negedge clk);
    end
    chk("R10 leds unchanged", led_out, 16'hE13C);
    chk("R10 tx idle", {8'h0, tx_byte}, 16'h0);
    do_write(7'h03, 8'h5F);
    chk("R2 alignment kept", led_out, 16'hE15F);
  endtask

  task automatic t_reset_mid;
    send(8'h84);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 leds cleared mid-command", led_out, 16'h0000);
    do_read("R1 command phase after reset", 7'h00, 8'h07);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_reads();
    t_writes();
    t_idle_noise();
    t_reset_mid();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule